// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface. It keeps the memory refreshed and moves it into and out of its low-power self-refresh state. A free-running interval counter raises a refresh obligation at a fixed cycle spacing. The sequencer holds that obligation until the access logic reports that every bank is idle, and then drives a single auto-refresh command. Obligations that pile up while the banks stay busy are counted. If too many are outstanding, a sticky error flag is raised.

On a sleep request, with all banks idle, the block drives the refresh command with the clock-enable pin low. It then parks the command pins in deselect for as long as the device refreshes itself. Interval ticks are thrown away during that time. On a wake request, clock enable goes high and NOPs are held for a recovery count. This is followed by a one-cycle DLL reset command and a fixed run of NOPs for DLL relock. Only after that does the ready flag tell the access logic it may use the memory again. The interval counter starts from zero at that point.

Timing values are given as parameters in nanoseconds and picoseconds and converted to cycles:
- The refresh interval is rounded down, so that no interval is ever stretched.
- The exit hold is rounded up.

Top module: `refresh_sleep_seq`

## Requirements
- R1: With `allIdle` high, an auto-refresh command (CKE high, CS low, RAS low, CAS low, WE high) appears INT_CYC+1 cycles after reset release, and every INT_CYC cycles after that. INT_CYC is REFWIN_NS*1000/CLK_PS rounded down.
- R2: No auto-refresh command is driven while `allIdle` is low. The obligation waits.
- R3: `owedLate` counts the refresh obligations outstanding beyond the first. It drops by one for each refresh issued.
- R4: Refreshes that are owed back-to-back are driven RFC_CYC+2 cycles apart. NOP (CS low, RAS/CAS/WE high) is driven between them, and `ready` is low during each refresh command.
- R5: Once more than 8 obligations are outstanding, `owedOverflow` rises and `owedLate` saturates at 7. The flag stays set until reset, even after the backlog drains.
- R6: In the ready state, `sleepReq` with `allIdle` high causes the following: one cycle of the refresh encoding with CKE low, then deselect (CS, RAS, CAS, WE high) with CKE low on every cycle, and `ready` low. `sleepReq` is ignored while `allIdle` is low.
- R7: A sleep request takes priority over a pending refresh. Entering self refresh clears the backlog.
- R8: While in self refresh, interval ticks are discarded, no command other than deselect is driven, and `owedLate` stays 0.
- R9: In the cycle after `wakeReq` is sampled, CKE is high and NOP is driven. After SNR_CYC cycles of NOP, one DLL reset command is driven (CKE high, CS, RAS, CAS, WE all low). SNR_CYC is SNR_NS*1000/CLK_PS rounded up.
- R10: After the DLL reset command, NOP is driven for DLL_WAIT cycles. `ready` then rises, DLL_WAIT+1 cycles after the DLL reset command began.
- R11: The interval counter restarts at exit. The first refresh after wake-up comes INT_CYC+1 cycles after `ready` rises.
- R12: During and after reset, the pins show NOP with CKE high, `ready` is high, and `owedLate` and `owedOverflow` are 0. `wakeReq` in the ready state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low reset |
| allIdle | input | 1 | High when every bank is precharged |
| sleepReq | input | 1 | Request to enter self refresh |
| wakeReq | input | 1 | Request to leave self refresh |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ready | output | 1 | Memory may be accessed |
| owedLate | output | OWE_W | Postponed refreshes beyond the first |
| owedOverflow | output | 1 | Sticky backlog overflow flag |

## Verification
The hardest condition to reach is the overflow boundary. It needs eight and then nine interval ticks to pass with the banks held busy, and that takes thousands of cycles without any command on the pins. The stimulus therefore holds `allIdle` low from reset release and samples the backlog and flag midway between the eighth and ninth ticks, and again after the ninth. It then releases the banks and expects a burst of exactly eight refreshes with the flag still set. The sleep-versus-refresh race is forced in a similar way: a backlog is built first, then the sleep request and the idle indication are raised in the same cycle.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_REF,
    ST_GAP,
    ST_SRIN,
    ST_SR,
    ST_XNOP,
    ST_DLLR,
    ST_DWAIT
  } seqState_e;

  typedef enum logic [1:0] {
    LD_RFC,
    LD_SNR,
    LD_DLL
  } phaseSel_e;

  typedef struct packed {
    logic      load;
    phaseSel_e ldSel;
    logic      refIssued;
    logic      srEnter;
    logic      hold;
  } ctrlStrobe_t;

endpackage

// File: rtl/rss_dpath.sv
module rss_dpath
  import rss_pkg::*;
#(
  parameter int INT_CYC  = 780,
  parameter int SNR_CYC  = 10,
  parameter int DLL_WAIT = 200,
  parameter int RFC_CYC  = 4,
  parameter int OWE_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  output logic             refPending,
  output logic [OWE_W-1:0] postponed,
  output logic             overflow,
  output logic             phaseDone
);

  localparam int INT_W  = (INT_CYC > 2) ? $clog2(INT_CYC) : 1;
  localparam int PH_TOP = (DLL_WAIT > SNR_CYC) ?
                          ((DLL_WAIT > RFC_CYC) ? DLL_WAIT : RFC_CYC) :
                          ((SNR_CYC > RFC_CYC) ? SNR_CYC : RFC_CYC);
  localparam int PH_W   = $clog2(PH_TOP + 1);
  localparam logic [INT_W-1:0] INT_LAST = INT_W'(INT_CYC - 1);
  localparam logic [OWE_W-1:0] OWE_FULL = '1;

  logic [INT_W-1:0] intCnt;
  logic             tick;
  logic [PH_W-1:0]  phCnt;
  logic [PH_W-1:0]  loadVal;

  // interval counter, parked at zero whenever the device is asleep or recovering
  assign tick = !stb.hold && (intCnt == INT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)                              intCnt <= '0;
    else if (stb.hold || intCnt == INT_LAST) intCnt <= '0;
    else                                     intCnt <= intCnt + 1'b1;
  end

  // refresh backlog: one pending bit plus a saturating count of later ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPending <= 1'b0;
      postponed  <= '0;
      overflow   <= 1'b0;
    end else if (stb.srEnter) begin
      refPending <= 1'b0;
      postponed  <= '0;
    end else begin
      unique case ({tick, stb.refIssued})
        2'b10: begin
          if (!refPending)                refPending <= 1'b1;
          else if (postponed == OWE_FULL) overflow   <= 1'b1;
          else                            postponed  <= postponed + 1'b1;
        end
        2'b01: begin
          if (postponed != '0) postponed  <= postponed - 1'b1;
          else                 refPending <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // phase timer shared by the refresh gap, exit hold and DLL relock wait
  always_comb begin
    unique case (stb.ldSel)
      LD_SNR:  loadVal = PH_W'(SNR_CYC - 1);
      LD_DLL:  loadVal = PH_W'(DLL_WAIT - 1);
      default: loadVal = PH_W'(RFC_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             phCnt <= '0;
    else if (stb.load)     phCnt <= loadVal;
    else if (phCnt != '0)  phCnt <= phCnt - 1'b1;
  end

  assign phaseDone = (phCnt == '0);

  p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_owed_clear_asleep_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.hold |=> (postponed == '0 && !refPending));

  p_owed_saturate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (postponed == OWE_FULL && !stb.refIssued && !stb.srEnter) |=> postponed == OWE_FULL);

endmodule

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allIdle,
  input  logic        sleepReq,
  input  logic        wakeReq,
  input  logic        refPending,
  input  logic        phaseDone,
  output ctrlStrobe_t stb,
  output logic        csN,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        cke,
  output logic        ready
);

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    stb.load      = 1'b0;
    stb.ldSel     = LD_RFC;
    stb.refIssued = 1'b0;
    stb.srEnter   = 1'b0;
    stb.hold      = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (sleepReq && allIdle)        nextState = ST_SRIN;
        else if (refPending && allIdle) nextState = ST_REF;
      end
      ST_REF: begin
        stb.refIssued = 1'b1;
        stb.load      = 1'b1;
        stb.ldSel     = LD_RFC;
        nextState     = ST_GAP;
      end
      ST_GAP:  if (phaseDone) nextState = ST_RUN;
      ST_SRIN: begin
        stb.srEnter = 1'b1;
        stb.hold    = 1'b1;
        nextState   = ST_SR;
      end
      ST_SR: begin
        stb.hold = 1'b1;
        if (wakeReq) begin
          stb.load  = 1'b1;
          stb.ldSel = LD_SNR;
          nextState = ST_XNOP;
        end
      end
      ST_XNOP: begin
        stb.hold = 1'b1;
        if (phaseDone) nextState = ST_DLLR;
      end
      ST_DLLR: begin
        stb.hold  = 1'b1;
        stb.load  = 1'b1;
        stb.ldSel = LD_DLL;
        nextState = ST_DWAIT;
      end
      ST_DWAIT: begin
        stb.hold = 1'b1;
        if (phaseDone) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  // pin decode: {cke, csN, rasN, casN, weN}
  always_comb begin
    unique case (state)
      ST_REF:  {cke, csN, rasN, casN, weN} = 5'b1_0001;
      ST_SRIN: {cke, csN, rasN, casN, weN} = 5'b0_0001;
      ST_SR:   {cke, csN, rasN, casN, weN} = 5'b0_1111;
      ST_DLLR: {cke, csN, rasN, casN, weN} = 5'b1_0000;
      default: {cke, csN, rasN, casN, weN} = 5'b1_0111;
    endcase
  end

  assign ready = (state == ST_RUN);

  p_ref_needs_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_REF |-> $past(allIdle));

  p_sleep_needs_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SRIN |-> ($past(allIdle) && $past(sleepReq)));

  p_dll_after_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DLLR |-> $past(state) == ST_XNOP);

  p_ready_awake_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cke && !csN));

  p_cke_rise_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> state == ST_XNOP);

endmodule

// File: rtl/refresh_sleep_seq.sv
module refresh_sleep_seq
  import rss_pkg::*;
#(
  parameter int CLK_PS    = 20000,
  parameter int REFWIN_NS = 15600,
  parameter int SNR_NS    = 200,
  parameter int DLL_WAIT  = 200,
  parameter int RFC_CYC   = 4,
  parameter int OWE_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allIdle,
  input  logic             sleepReq,
  input  logic             wakeReq,
  output logic             csN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             cke,
  output logic             ready,
  output logic [OWE_W-1:0] owedLate,
  output logic             owedOverflow
);

  // interval rounded down so no interval is ever stretched; exit hold rounded up
  localparam int INT_CYC = (REFWIN_NS * 1000) / CLK_PS;
  localparam int SNR_CYC = (SNR_NS * 1000 + CLK_PS - 1) / CLK_PS;

  ctrlStrobe_t stb;
  logic        refPending;
  logic        phaseDone;

  rss_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allIdle    (allIdle),
    .sleepReq   (sleepReq),
    .wakeReq    (wakeReq),
    .refPending (refPending),
    .phaseDone  (phaseDone),
    .stb        (stb),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .cke        (cke),
    .ready      (ready)
  );

  rss_dpath #(
    .INT_CYC  (INT_CYC),
    .SNR_CYC  (SNR_CYC),
    .DLL_WAIT (DLL_WAIT),
    .RFC_CYC  (RFC_CYC),
    .OWE_W    (OWE_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .refPending (refPending),
    .postponed  (owedLate),
    .overflow   (owedOverflow),
    .phaseDone  (phaseDone)
  );

endmodule

// File: tb/refresh_sleep_seq_bench.sv
`timescale 1ns/1ps
module refresh_sleep_seq_bench;

  localparam int INT_CYC  = 780;   // 15600 ns / 20 ns
  localparam int SNR_CYC  = 10;    // 200 ns / 20 ns
  localparam int DLL_WAIT = 200;
  localparam int RFC_CYC  = 4;

  localparam logic [4:0] C_NOP  = 5'b1_0111;
  localparam logic [4:0] C_REF  = 5'b1_0001;
  localparam logic [4:0] C_SRIN = 5'b0_0001;
  localparam logic [4:0] C_DES  = 5'b0_1111;
  localparam logic [4:0] C_DLLR = 5'b1_0000;

  logic clk = 1'b0;
  logic rstN, allIdle, sleepReq, wakeReq;
  logic csN, rasN, casN, weN, cke, ready, owedOverflow;
  logic [2:0] owedLate;

  int checks = 0, bad = 0;
  int cyc = 0, evCount = 0, lastEvCyc = 0;
  int t1, wakeCyc, base;
  bit done = 1'b0;
  logic [4:0] expQ[$];
  logic [4:0] prevCmd = C_NOP;

  always #10 clk = ~clk;

  refresh_sleep_seq u_refresh_sleep_seq (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke), .ready(ready),
    .owedLate(owedLate), .owedOverflow(owedOverflow)
  );

  function automatic logic [4:0] pins();
    return {cke, csN, rasN, casN, weN};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // monitor: every change to a non-NOP command pops one expected item
  always @(negedge clk) begin
    logic [4:0] cur;
    logic [4:0] want;
    if (!rstN) prevCmd = C_NOP;
    else begin
      cur = pins();
      if (cur != prevCmd && cur != C_NOP) begin
        evCount++;
        lastEvCyc = cyc;
        if (expQ.size() == 0) chk("scoreboard unexpected command", int'(cur), int'(C_NOP));
        else begin
          want = expQ.pop_front();
          chk("scoreboard command R1 R6 R9", int'(cur), int'(want));
        end
        if (cur == C_REF) chk("R4 ready low during refresh", int'(ready), 0);
      end
      prevCmd = cur;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) tick();
  endtask

  task automatic waitEv(input int k);
    while (evCount < k) tick();
  endtask

  initial begin
    rstN = 1'b0; allIdle = 1'b1; sleepReq = 1'b0; wakeReq = 1'b0;
    repeat (3) tick();
    chk("R12 reset command", int'(pins()), int'(C_NOP));
    chk("R12 reset ready", int'(ready), 1);
    chk("R12 reset owed", int'(owedLate), 0);
    chk("R12 reset overflow", int'(owedOverflow), 0);
    expQ.push_back(C_REF); expQ.push_back(C_REF);
    rstN = 1'b1;

    waitEv(1);
    chk("R1 first refresh cycle", lastEvCyc, INT_CYC + 1);
    t1 = lastEvCyc;
    waitEv(2);
    chk("R1 refresh interval", lastEvCyc - t1, INT_CYC);

    // banks busy across three ticks
    waitCyc(1570); allIdle = 1'b0;
    waitCyc(3950);
    chk("R3 owed after three held ticks", int'(owedLate), 2);
    chk("R2 no refresh while busy", evCount, 2);
    repeat (3) expQ.push_back(C_REF);
    allIdle = 1'b1;
    waitEv(3); t1 = lastEvCyc;
    waitEv(4);
    chk("R4 back-to-back spacing", lastEvCyc - t1, RFC_CYC + 2);
    t1 = lastEvCyc;
    waitEv(5);
    chk("R4 back-to-back spacing second", lastEvCyc - t1, RFC_CYC + 2);
    waitCyc(lastEvCyc + RFC_CYC + 3);
    chk("R3 backlog drained", int'(owedLate), 0);
    chk("R4 ready back after gap", int'(ready), 1);

    // sleep ignored while busy
    allIdle = 1'b0; sleepReq = 1'b1;
    repeat (5) tick();
    chk("R6 sleep ignored cke", int'(cke), 1);
    chk("R6 sleep ignored ready", int'(ready), 1);
    chk("R6 sleep ignored no command", evCount, 5);
    expQ.push_back(C_SRIN); expQ.push_back(C_DES);
    allIdle = 1'b1;
    waitEv(7);
    sleepReq = 1'b0;
    chk("R6 ready low asleep", int'(ready), 0);

    // self refresh across two interval lengths
    t1 = cyc;
    waitCyc(t1 + 2000);
    chk("R8 no command asleep", evCount, 7);
    chk("R8 owed stays zero", int'(owedLate), 0);
    chk("R8 cke low asleep", int'(cke), 0);
    chk("R8 deselect asleep", int'(csN), 1);

    // wake up
    expQ.push_back(C_DLLR);
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    wakeCyc = cyc;
    chk("R9 cke high after wake", int'(cke), 1);
    chk("R9 nop after wake", int'(pins()), int'(C_NOP));
    waitEv(8);
    chk("R9 nop hold length", lastEvCyc - wakeCyc, SNR_CYC);
    waitCyc(wakeCyc + SNR_CYC + DLL_WAIT);
    chk("R10 ready still low", int'(ready), 0);
    waitCyc(wakeCyc + SNR_CYC + DLL_WAIT + 1);
    chk("R10 ready after relock wait", int'(ready), 1);
    chk("R10 relock wait length", cyc - lastEvCyc, DLL_WAIT + 1);
    expQ.push_back(C_REF);
    waitEv(9);
    chk("R11 interval restart", lastEvCyc - (wakeCyc + SNR_CYC + DLL_WAIT + 1), INT_CYC + 1);

    // sleep versus pending refresh
    t1 = lastEvCyc;
    allIdle = 1'b0;
    waitCyc(t1 + 2 * INT_CYC + 40);
    chk("R3 owed before sleep", int'(owedLate), 1);
    expQ.push_back(C_SRIN); expQ.push_back(C_DES);
    sleepReq = 1'b1; allIdle = 1'b1;
    waitEv(11);
    sleepReq = 1'b0;
    tick();
    chk("R7 backlog cleared on sleep", int'(owedLate), 0);

    // overflow from a fresh reset
    rstN = 1'b0; allIdle = 1'b0;
    repeat (3) tick();
    chk("R12 reset cke", int'(cke), 1);
    chk("R12 reset ready again", int'(ready), 1);
    rstN = 1'b1;
    waitCyc(8 * INT_CYC + 100);
    chk("R5 owed at eight outstanding", int'(owedLate), 7);
    chk("R5 no overflow at eight", int'(owedOverflow), 0);
    waitCyc(9 * INT_CYC + 100);
    chk("R5 overflow at nine", int'(owedOverflow), 1);
    chk("R5 owed saturated", int'(owedLate), 7);
    base = evCount;
    repeat (8) expQ.push_back(C_REF);
    allIdle = 1'b1;
    waitEv(base + 8);
    waitCyc(lastEvCyc + RFC_CYC + 3);
    chk("R5 backlog drained", int'(owedLate), 0);
    chk("R5 overflow sticky", int'(owedOverflow), 1);

    // wake request while running
    wakeReq = 1'b1;
    tick();
    wakeReq = 1'b0;
    tick();
    chk("R12 wake ignored cke", int'(cke), 1);
    chk("R12 wake ignored ready", int'(ready), 1);
    chk("R12 wake ignored no command", evCount, base + 8);
    chk("scoreboard all expected seen", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule